// File: doc/BRIEF.md
# Variable-Length Instruction Fetch and Operand Decoder

This block pulls one instruction of a byte-coded, variable-length instruction set out of a byte-wide memory and turns it into decoded fields. It reads the leading opcode byte. A built-in map turns that byte into the type of each operand. The block then reads the zero to four operand bytes that follow, one byte per cycle, at consecutive addresses. It reports the opcode, both operand types, a resolved 16-bit value for each operand, the total length in bytes and an illegal flag. Executing the instruction is left to the core that consumes these fields.

A register-plus-offset operand is resolved here. Its first byte names one of the five 16-bit registers, whose values the core presents on a flat input bus with index 0 in the low bits. Its second byte is a signed offset. Their sum, taken modulo 2^16, is the effective address. Memory reads are combinational: the data byte for `mem_addr` must be valid in the same cycle.

Top module: `vlen_fetch_decoder`

## Requirements
- R1: After a synchronous reset, `done`, `illegal` and `mem_rd` are 0. `opcode`, both kinds, both values and `length` are 0.
- R2: A `start` seen while idle makes the block read `start_addr` in the next cycle. Each following cycle reads the next address while `mem_rd` is 1. A `start` that arrives during a fetch is ignored.
- R3: The operand-kind codes are none=0, 8-bit immediate=1, 16-bit immediate=2, absolute address=3, byte register=4, word register=5, register-plus-offset=6. The opcode map is as follows. 0x00, 0x47 and 0x82–0x86 have no operand. 0x01–0x08 are (5,5),(5,6),(5,3),(6,5),(3,5),(5,2),(6,2),(3,2). 0x09–0x10 are (4,4),(4,6),(4,3),(6,4),(3,4),(4,1),(6,1),(3,1).
- R4: The word-register two-operand groups start at 0x11, 0x19, 0x25, 0x58, 0x60, 0x68, 0x72 and 0x7A. Each takes first kind 5 and second kind 5, 6, 3, 2 in ascending opcode order. The byte-register groups at 0x15 and 0x29 take first kind 4 and second kind 4, 6, 3, 1. The byte-register groups at 0x1D, 0x5C, 0x64, 0x6C, 0x76 and 0x7E take second kind 4, 6, 3, 2.
- R5: The single-operand groups at 0x3B, 0x48, 0x50, 0x87 and 0x8B take kinds 5, 6, 3, 2. The groups at 0x4C and 0x54 take 4, 6, 3, 1. The group at 0x3F takes 4, 6, 3, 2. Opcodes 0x21, 0x23, 0x43 and 0x70 take kind 5, and 0x22, 0x24, 0x44 and 0x71 take kind 4. In 0x2D–0x3A an odd opcode takes kind 6 and an even one kind 2. 0x45 takes kind 6 and 0x46 kind 2.
- R6: Kinds 1, 4 and 5 occupy one byte, and kinds 2, 3 and 6 occupy two. `length` is 1 plus the operand sizes. `done` rises for one cycle in the cycle after the last byte is read, so a fetch of L bytes shows `done` L cycles after the first read cycle.
- R7: Two-byte immediates and addresses are big-endian: the first byte is the high byte.
- R8: For kind 6, the first byte is a register index 0–4 (A, B, C, D, SP) and the second an offset in -128..127. The value is the register plus the sign-extended offset, modulo 2^16.
- R9: For kinds 4 and 5 the value is the register index. For kind 1 the value is the byte zero-extended.
- R10: Opcodes 0x8F–0xFF are undefined. They give `illegal`=1, `length`=1, both kinds 0 and both values 0.
- R11: A word-register or offset-base index above 4, or a byte-register index outside 9–16, sets `illegal`. The fetch ends after that operand, and `length` counts the bytes read so far. The kinds still show the map entry.
- R12: `done` is a single-cycle pulse. All result outputs hold their values until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a fetch at `start_addr` when idle |
| start_addr | input | 16 | Address of the opcode byte |
| regs_flat | input | 80 | Five 16-bit register values, index 0 in bits 15:0 |
| mem_rd | output | 1 | Fetch in progress; `mem_addr` is being read |
| mem_addr | output | 16 | Byte address being read |
| mem_rdata | input | 8 | Byte at `mem_addr`, same cycle |
| done | output | 1 | One-cycle pulse: results valid |
| illegal | output | 1 | Undefined opcode or bad register index |
| opcode | output | 8 | Captured opcode byte |
| op1_kind | output | 3 | First operand kind code |
| op2_kind | output | 3 | Second operand kind code |
| op1_val | output | 16 | First operand resolved value |
| op2_val | output | 16 | Second operand resolved value |
| length | output | 3 | Instruction length in bytes, 1 to 5 |

## Verification
The `done` pulse of one instruction can fall in the same cycle as a `start` for the next. The bench provokes this by raising `start` with a new address in the cycle where it sees `done`. It then checks that the second fetch begins at once, reads from the new address and resolves its own operands. A `start` that arrives during the operand bytes of a five-byte fetch must be dropped. This case is judged by the address sequence and by the unchanged results of the first instruction.

// File: rtl/vfd_pkg.sv
package vfd_pkg;

    localparam int ADDR_W  = 16;
    localparam int WORD_W  = 16;
    localparam int BYTE_W  = 8;
    localparam int NREG16  = 5;
    localparam int R8_BASE = 9;
    localparam int NREG8   = 8;
    localparam int LEN_W   = 3;

    typedef enum logic [2:0] {
        K_NONE   = 3'd0,
        K_IMM8   = 3'd1,
        K_IMM16  = 3'd2,
        K_ABS    = 3'd3,
        K_REG8   = 3'd4,
        K_REG16  = 3'd5,
        K_REGOFF = 3'd6
    } okind_t;

    typedef struct packed {
        logic   legal;
        okind_t k1;
        okind_t k2;
    } opinfo_t;

    // Second-position source for the word-register families.
    function automatic okind_t src_word(input logic [1:0] sel);
        case (sel)
            2'd0:    return K_REG16;
            2'd1:    return K_REGOFF;
            2'd2:    return K_ABS;
            default: return K_IMM16;
        endcase
    endfunction

    // Second-position source for the byte-register families.
    function automatic okind_t src_byte(input logic [1:0] sel, input logic wide_imm);
        case (sel)
            2'd0:    return K_REG8;
            2'd1:    return K_REGOFF;
            2'd2:    return K_ABS;
            default: return wide_imm ? K_IMM16 : K_IMM8;
        endcase
    endfunction

    function automatic logic [LEN_W-1:0] kind_bytes(input okind_t k);
        case (k)
            K_IMM8, K_REG8, K_REG16:  return 3'd1;
            K_IMM16, K_ABS, K_REGOFF: return 3'd2;
            default:                  return 3'd0;
        endcase
    endfunction

    function automatic opinfo_t opcode_info(input logic [7:0] op);
        opinfo_t r;
        r.legal = 1'b1;
        r.k1    = K_NONE;
        r.k2    = K_NONE;
        case (op) inside
            8'h00, 8'h47, [8'h82:8'h86]: ;
            [8'h01:8'h08]: begin
                case (op[3:0])
                    4'h1: begin r.k1 = K_REG16;  r.k2 = K_REG16;  end
                    4'h2: begin r.k1 = K_REG16;  r.k2 = K_REGOFF; end
                    4'h3: begin r.k1 = K_REG16;  r.k2 = K_ABS;    end
                    4'h4: begin r.k1 = K_REGOFF; r.k2 = K_REG16;  end
                    4'h5: begin r.k1 = K_ABS;    r.k2 = K_REG16;  end
                    4'h6: begin r.k1 = K_REG16;  r.k2 = K_IMM16;  end
                    4'h7: begin r.k1 = K_REGOFF; r.k2 = K_IMM16;  end
                    default: begin r.k1 = K_ABS; r.k2 = K_IMM16;  end
                endcase
            end
            [8'h09:8'h10]: begin
                case (op[3:0])
                    4'h9: begin r.k1 = K_REG8;   r.k2 = K_REG8;   end
                    4'hA: begin r.k1 = K_REG8;   r.k2 = K_REGOFF; end
                    4'hB: begin r.k1 = K_REG8;   r.k2 = K_ABS;    end
                    4'hC: begin r.k1 = K_REGOFF; r.k2 = K_REG8;   end
                    4'hD: begin r.k1 = K_ABS;    r.k2 = K_REG8;   end
                    4'hE: begin r.k1 = K_REG8;   r.k2 = K_IMM8;   end
                    4'hF: begin r.k1 = K_REGOFF; r.k2 = K_IMM8;   end
                    default: begin r.k1 = K_ABS; r.k2 = K_IMM8;   end
                endcase
            end
            [8'h11:8'h14], [8'h19:8'h1C], [8'h25:8'h28]: begin
                r.k1 = K_REG16; r.k2 = src_word(op[1:0] - 2'd1);
            end
            [8'h58:8'h5B], [8'h60:8'h63], [8'h68:8'h6B]: begin
                r.k1 = K_REG16; r.k2 = src_word(op[1:0]);
            end
            [8'h72:8'h75], [8'h7A:8'h7D]: begin
                r.k1 = K_REG16; r.k2 = src_word(op[1:0] - 2'd2);
            end
            [8'h15:8'h18], [8'h29:8'h2C]: begin
                r.k1 = K_REG8; r.k2 = src_byte(op[1:0] - 2'd1, 1'b0);
            end
            [8'h1D:8'h20]: begin
                r.k1 = K_REG8; r.k2 = src_byte(op[1:0] - 2'd1, 1'b1);
            end
            [8'h5C:8'h5F], [8'h64:8'h67], [8'h6C:8'h6F]: begin
                r.k1 = K_REG8; r.k2 = src_byte(op[1:0], 1'b1);
            end
            [8'h76:8'h79], [8'h7E:8'h81]: begin
                r.k1 = K_REG8; r.k2 = src_byte(op[1:0] - 2'd2, 1'b1);
            end
            8'h21, 8'h23, 8'h43, 8'h70: r.k1 = K_REG16;
            8'h22, 8'h24, 8'h44, 8'h71: r.k1 = K_REG8;
            [8'h2D:8'h3A]:              r.k1 = op[0] ? K_REGOFF : K_IMM16;
            8'h45:                      r.k1 = K_REGOFF;
            8'h46:                      r.k1 = K_IMM16;
            [8'h3B:8'h3E], [8'h87:8'h8A], [8'h8B:8'h8E]:
                                        r.k1 = src_word(op[1:0] - 2'd3);
            [8'h48:8'h4B], [8'h50:8'h53]:
                                        r.k1 = src_word(op[1:0]);
            [8'h3F:8'h42]:              r.k1 = src_byte(op[1:0] - 2'd3, 1'b1);
            [8'h4C:8'h4F], [8'h54:8'h57]:
                                        r.k1 = src_byte(op[1:0], 1'b0);
            default:                    r.legal = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/vfd_opmap.sv
module vfd_opmap
    import vfd_pkg::*;
(
    input  logic [7:0]       op,
    output opinfo_t          info,
    output logic [LEN_W-1:0] first_bytes,
    output logic [LEN_W-1:0] operand_bytes
);
    always_comb begin
        info          = opcode_info(op);
        first_bytes   = kind_bytes(info.k1);
        operand_bytes = kind_bytes(info.k1) + kind_bytes(info.k2);
    end
endmodule

// File: rtl/vfd_resolve.sv
module vfd_resolve
    import vfd_pkg::*;
#(
    parameter int W    = WORD_W,
    parameter int NREG = NREG16
) (
    input  okind_t          kind,
    input  logic [W-1:0]    raw,
    input  logic [NREG*W-1:0] regs,
    output logic [W-1:0]    val,
    output logic            bad
);
    localparam int SEL_W = (NREG > 1) ? $clog2(NREG) : 1;
    localparam logic [7:0] NREG_B = 8'(NREG);
    localparam logic [7:0] R8_LO  = 8'(R8_BASE);
    localparam logic [7:0] R8_HI  = 8'(R8_BASE + NREG8 - 1);

    logic [W-1:0] bank [NREG];
    for (genvar g = 0; g < NREG; g++) begin : g_bank
        assign bank[g] = regs[g*W +: W];
    end

    logic [7:0]       lo_b;
    logic [7:0]       hi_b;
    logic [SEL_W-1:0] sel;
    logic [W-1:0]     base;
    logic [W-1:0]     offs;

    assign lo_b = raw[7:0];
    assign hi_b = raw[15:8];

    always_comb begin
        sel  = (hi_b < NREG_B) ? hi_b[SEL_W-1:0] : '0;
        base = bank[sel];
        offs = {{(W-8){lo_b[7]}}, lo_b};
        val  = raw;
        bad  = 1'b0;
        case (kind)
            K_REG16: begin
                val = W'(lo_b);
                bad = (lo_b >= NREG_B);
            end
            K_REG8: begin
                val = W'(lo_b);
                bad = (lo_b < R8_LO) || (lo_b > R8_HI);
            end
            K_REGOFF: begin
                val = base + offs;
                bad = (hi_b >= NREG_B);
            end
            K_IMM8:  val = W'(lo_b);
            K_NONE:  val = '0;
            default: val = raw;
        endcase
    end
endmodule

// File: rtl/vlen_fetch_decoder.sv
module vlen_fetch_decoder
    import vfd_pkg::*;
#(
    parameter int AW   = ADDR_W,
    parameter int DW   = WORD_W,
    parameter int NREG = NREG16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [AW-1:0]      start_addr,
    input  logic [NREG*DW-1:0] regs_flat,
    output logic               mem_rd,
    output logic [AW-1:0]      mem_addr,
    input  logic [7:0]         mem_rdata,
    output logic               done,
    output logic               illegal,
    output logic [7:0]         opcode,
    output logic [2:0]         op1_kind,
    output logic [2:0]         op2_kind,
    output logic [DW-1:0]      op1_val,
    output logic [DW-1:0]      op2_val,
    output logic [LEN_W-1:0]   length
);
    localparam int NOPS = 2;

    typedef enum logic [1:0] {ST_IDLE, ST_OPC, ST_OPND} state_t;

    state_t            state;
    logic [AW-1:0]     pc;
    logic [LEN_W-1:0]  cnt;
    logic [LEN_W-1:0]  len1_q;
    logic [LEN_W-1:0]  tot_q;
    okind_t            kind_q [NOPS];
    logic [DW-1:0]     raw_q  [NOPS];
    logic [DW-1:0]     val_q  [NOPS];
    logic              done_q;
    logic              ill_q;
    logic [7:0]        opc_q;
    logic [LEN_W-1:0]  len_q;

    opinfo_t           info_now;
    logic [LEN_W-1:0]  first_now;
    logic [LEN_W-1:0]  tot_now;

    vfd_opmap u_map (
        .op           (mem_rdata),
        .info         (info_now),
        .first_bytes  (first_now),
        .operand_bytes(tot_now)
    );

    logic             cur_op;
    logic             cur_last;
    logic [DW-1:0]    raw_in  [NOPS];
    logic [DW-1:0]    res_val [NOPS];
    logic             res_bad [NOPS];

    assign cur_op   = (cnt >= len1_q);
    assign cur_last = cur_op ? ((cnt + 3'd1) == tot_q) : ((cnt + 3'd1) == len1_q);

    for (genvar n = 0; n < NOPS; n++) begin : g_opnd
        assign raw_in[n] = (cur_op == 1'(n)) ? {raw_q[n][DW-9:0], mem_rdata} : raw_q[n];
        vfd_resolve #(.W(DW), .NREG(NREG)) u_res (
            .kind(kind_q[n]),
            .raw (raw_in[n]),
            .regs(regs_flat),
            .val (res_val[n]),
            .bad (res_bad[n])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            pc        <= '0;
            cnt       <= '0;
            len1_q    <= '0;
            tot_q     <= '0;
            done_q    <= 1'b0;
            ill_q     <= 1'b0;
            opc_q     <= '0;
            len_q     <= '0;
            for (int n = 0; n < NOPS; n++) begin
                kind_q[n] <= K_NONE;
                raw_q[n]  <= '0;
                val_q[n]  <= '0;
            end
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        pc    <= start_addr;
                        cnt   <= '0;
                        state <= ST_OPC;
                        for (int n = 0; n < NOPS; n++) raw_q[n] <= '0;
                    end
                end
                ST_OPC: begin
                    pc       <= pc + 1'b1;
                    opc_q    <= mem_rdata;
                    val_q[0] <= '0;
                    val_q[1] <= '0;
                    if (!info_now.legal) begin
                        ill_q     <= 1'b1;
                        kind_q[0] <= K_NONE;
                        kind_q[1] <= K_NONE;
                        len_q     <= 3'd1;
                        done_q    <= 1'b1;
                        state     <= ST_IDLE;
                    end else begin
                        ill_q     <= 1'b0;
                        kind_q[0] <= info_now.k1;
                        kind_q[1] <= info_now.k2;
                        len1_q    <= first_now;
                        tot_q     <= tot_now;
                        if (tot_now == '0) begin
                            len_q  <= 3'd1;
                            done_q <= 1'b1;
                            state  <= ST_IDLE;
                        end else begin
                            state  <= ST_OPND;
                        end
                    end
                end
                ST_OPND: begin
                    pc             <= pc + 1'b1;
                    cnt            <= cnt + 3'd1;
                    raw_q[cur_op]  <= raw_in[cur_op];
                    if (cur_last) begin
                        val_q[cur_op] <= res_val[cur_op];
                        if (res_bad[cur_op]) begin
                            ill_q  <= 1'b1;
                            len_q  <= cnt + 3'd2;
                            done_q <= 1'b1;
                            state  <= ST_IDLE;
                        end else if (cur_op || (len1_q == tot_q)) begin
                            len_q  <= tot_q + 3'd1;
                            done_q <= 1'b1;
                            state  <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign mem_rd   = (state != ST_IDLE);
    assign mem_addr = pc;
    assign done     = done_q;
    assign illegal  = ill_q;
    assign opcode   = opc_q;
    assign op1_kind = kind_q[0];
    assign op2_kind = kind_q[1];
    assign op1_val  = val_q[0];
    assign op2_val  = val_q[1];
    assign length   = len_q;
endmodule

// File: rtl/vfd_checker.sv
module vfd_checker (
    input logic        clk,
    input logic        rst,
    input logic [15:0] start_addr,
    input logic        mem_rd,
    input logic [15:0] mem_addr,
    input logic        done,
    input logic        illegal,
    input logic [2:0]  op1_kind,
    input logic [2:0]  op2_kind,
    input logic [15:0] op1_val,
    input logic [15:0] op2_val,
    input logic [2:0]  length
);
    p_first_addr_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_rd) |-> mem_addr == $past(start_addr));

    p_next_addr_r2: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && $past(mem_rd)) |-> mem_addr == $past(mem_addr) + 16'd1);

    p_len_range_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> (length >= 3'd1 && length <= 3'd5));

    p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> !mem_rd);

    p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_kind_order_r3: assert property (@(posedge clk) disable iff (rst)
        (done && !illegal && op1_kind == 3'd0) |-> op2_kind == 3'd0);

    p_reg_index_r9: assert property (@(posedge clk) disable iff (rst)
        (done && !illegal && op1_kind == 3'd5) |-> op1_val <= 16'd4);

    p_undef_len_r10: assert property (@(posedge clk) disable iff (rst)
        (done && illegal && op1_kind == 3'd0) |-> length == 3'd1);

    p_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (!mem_rd && !done) |-> ($stable(op1_val) && $stable(op2_val) && $stable(length)));
endmodule

bind vlen_fetch_decoder vfd_checker u_vfd_checker (
    .clk       (clk),
    .rst       (rst),
    .start_addr(start_addr),
    .mem_rd    (mem_rd),
    .mem_addr  (mem_addr),
    .done      (done),
    .illegal   (illegal),
    .op1_kind  (op1_kind),
    .op2_kind  (op2_kind),
    .op1_val   (op1_val),
    .op2_val   (op2_val),
    .length    (length)
);

// File: tb/test_vlen_fetch_decoder.sv
module test_vlen_fetch_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] start_addr = '0;
    logic [79:0] regs_flat;
    logic        mem_rd;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata;
    logic        done;
    logic        illegal;
    logic [7:0]  opcode;
    logic [2:0]  op1_kind, op2_kind;
    logic [15:0] op1_val, op2_val;
    logic [2:0]  length;

    always #2 clk = ~clk;

    logic [7:0]  mem [1024];
    logic [15:0] breg [5];

    assign mem_rdata = mem[mem_addr[9:0]];
    assign regs_flat = {breg[4], breg[3], breg[2], breg[1], breg[0]};

    vlen_fetch_decoder i_vlen_fetch_decoder (
        .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
        .regs_flat(regs_flat), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .done(done), .illegal(illegal),
        .opcode(opcode), .op1_kind(op1_kind), .op2_kind(op2_kind),
        .op1_val(op1_val), .op2_val(op2_val), .length(length)
    );

    int checks = 0;
    int errors = 0;

    typedef struct {
        int op; int len; bit ill; int k1; int k2; int v1; int v2;
    } exp_t;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
        end
    endtask

    function automatic int sz(input int k);
        if (k == 1 || k == 4 || k == 5) return 1;
        if (k == 2 || k == 3 || k == 6) return 2;
        return 0;
    endfunction

    // Independent model of the opcode map (R3, R4, R5, R10).
    function automatic void model_map(input int op, output int lg, output int a, output int b);
        int w2[4]  = '{5, 6, 3, 2};
        int b8[4]  = '{4, 6, 3, 1};
        int b16[4] = '{4, 6, 3, 2};
        int g16[8] = '{'h11, 'h19, 'h25, 'h58, 'h60, 'h68, 'h72, 'h7A};
        int gb8[2] = '{'h15, 'h29};
        int gb16[6] = '{'h1D, 'h5C, 'h64, 'h6C, 'h76, 'h7E};
        int s16[5] = '{'h3B, 'h48, 'h50, 'h87, 'h8B};
        int m1[8]  = '{5, 5, 5, 6, 3, 5, 6, 3};
        int m2[8]  = '{5, 6, 3, 5, 5, 2, 2, 2};
        lg = 1; a = 0; b = 0;
        if (op == 0 || op == 'h47 || (op >= 'h82 && op <= 'h86)) return;
        if (op >= 1 && op <= 8) begin a = m1[op-1]; b = m2[op-1]; return; end
        if (op >= 9 && op <= 16) begin
            a = (m1[op-9] == 5) ? 4 : m1[op-9];
            b = (m2[op-9] == 5) ? 4 : ((m2[op-9] == 2) ? 1 : m2[op-9]);
            return;
        end
        foreach (g16[i]) if (op >= g16[i] && op < g16[i]+4) begin a = 5; b = w2[op-g16[i]]; return; end
        foreach (gb8[i]) if (op >= gb8[i] && op < gb8[i]+4) begin a = 4; b = b8[op-gb8[i]]; return; end
        foreach (gb16[i]) if (op >= gb16[i] && op < gb16[i]+4) begin a = 4; b = b16[op-gb16[i]]; return; end
        foreach (s16[i]) if (op >= s16[i] && op < s16[i]+4) begin a = w2[op-s16[i]]; return; end
        if (op >= 'h4C && op <= 'h4F) begin a = b8[op-'h4C]; return; end
        if (op >= 'h54 && op <= 'h57) begin a = b8[op-'h54]; return; end
        if (op >= 'h3F && op <= 'h42) begin a = b16[op-'h3F]; return; end
        if (op == 'h21 || op == 'h23 || op == 'h43 || op == 'h70) begin a = 5; return; end
        if (op == 'h22 || op == 'h24 || op == 'h44 || op == 'h71) begin a = 4; return; end
        if ((op >= 'h2D && op <= 'h3A) || op == 'h45 || op == 'h46) begin a = (op % 2 == 1) ? 6 : 2; return; end
        lg = 0;
    endfunction

    // Build an instruction in memory; bad_op selects which operand (1 or 2) gets a bad register index.
    task automatic build(input int op, input int base, input int bad_op, output exp_t e);
        int lg, k[2], v[2], n, bt;
        logic [7:0] by [5];
        model_map(op, lg, k[0], k[1]);
        by[0] = 8'(op); n = 1; v[0] = 0; v[1] = 0;
        e.op = op; e.ill = (lg == 0);
        e.k1 = lg ? k[0] : 0; e.k2 = lg ? k[1] : 0;
        e.len = 1;
        if (lg) begin
            for (int o = 0; o < 2; o++) begin
                bit bad = (bad_op == o + 1);
                int r, off;
                case (k[o])
                    1: begin bt = $urandom % 256; by[n] = 8'(bt); v[o] = bt; n++; end
                    2, 3: begin bt = $urandom % 65536; by[n] = 8'(bt >> 8); by[n+1] = 8'(bt); v[o] = bt; n += 2; end
                    4: begin
                        bt = bad ? (($urandom % 2) ? ($urandom % 9) : (17 + $urandom % 239)) : (9 + $urandom % 8);
                        by[n] = 8'(bt); v[o] = bt; n++;
                    end
                    5: begin
                        bt = bad ? (5 + $urandom % 251) : ($urandom % 5);
                        by[n] = 8'(bt); v[o] = bt; n++;
                    end
                    6: begin
                        r = bad ? (5 + $urandom % 251) : ($urandom % 5);
                        off = $urandom % 256;
                        by[n] = 8'(r); by[n+1] = 8'(off); n += 2;
                        if (!bad) v[o] = (breg[r] + ((off >= 128) ? off - 256 : off)) & 'hFFFF;
                    end
                    default: ;
                endcase
                if (bad && k[o] >= 4) begin e.ill = 1; break; end
            end
            e.len = n;
        end
        e.v1 = v[0]; e.v2 = v[1];
        for (int i = 0; i < n; i++) mem[(base + i) % 1024] = by[i];
    endtask

    task automatic launch(input int base);
        start = 1'b1; start_addr = 16'(base);
        @(negedge clk);
        start = 1'b0;
        chk(mem_rd === 1'b1 && mem_addr === 16'(base), "R2 first read address", int'(mem_addr), base);
    endtask

    task automatic wait_done(output int cyc);
        cyc = 0;
        while (done !== 1'b1 && cyc < 40) begin @(negedge clk); cyc++; end
    endtask

    task automatic judge(input exp_t e, input int cyc);
        chk(cyc == e.len, "R6 done latency", cyc, e.len);
        chk(int'(length) == e.len, "R6 length", int'(length), e.len);
        chk(illegal == e.ill, (e.k1 == 0 && e.ill) ? "R10 illegal flag" : "R11 illegal flag", int'(illegal), int'(e.ill));
        chk(int'(opcode) == e.op, "R3 opcode", int'(opcode), e.op);
        chk(int'(op1_kind) == e.k1 && int'(op2_kind) == e.k2, "R4 R5 operand kinds",
            int'({op1_kind, op2_kind}), (e.k1 << 3) | e.k2);
        if (!e.ill || e.k1 == 0)
            chk(int'(op1_val) == e.v1 && int'(op2_val) == e.v2, "R7 R8 R9 operand values",
                int'({op1_val, op2_val}), (e.v1 << 16) | e.v2);
    endtask

    task automatic run_one(input int op, input int base, input int bad_op);
        exp_t e; int cyc;
        build(op, base, bad_op, e);
        launch(base);
        wait_done(cyc);
        judge(e, cyc);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        exp_t e1, e2;
        int cyc, base;
        logic [15:0] hold;
        void'($urandom(32'd2024));
        foreach (mem[i]) mem[i] = 8'(i * 7);
        foreach (breg[i]) breg[i] = 16'($urandom);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(done == 0 && illegal == 0 && mem_rd == 0, "R1 reset flags", int'({done, illegal, mem_rd}), 0);
        chk(opcode == 0 && op1_kind == 0 && op2_kind == 0 && op1_val == 0 && op2_val == 0 && length == 0,
            "R1 reset results", int'(length), 0);

        // Sweep every opcode (R3, R4, R5, R10)
        for (int op = 0; op < 256; op++) run_one(op, ($urandom % 900) + 16, 0);

        // Random legal opcodes with random operands
        for (int i = 0; i < 400; i++) begin
            int op, lg, a, b;
            do begin op = $urandom % 143; model_map(op, lg, a, b); end while (!lg);
            foreach (breg[j]) breg[j] = 16'($urandom);
            run_one(op, ($urandom % 900) + 16, 0);
        end

        // R11 bad register indices in first and second operand
        run_one('h01, 40, 1); run_one('h01, 60, 2); run_one('h09, 80, 1);
        run_one('h09, 100, 2); run_one('h02, 120, 2); run_one('h2D, 140, 1);
        run_one('h0C, 160, 1); run_one('h22, 180, 1); run_one('h8C, 200, 1);
        for (int i = 0; i < 30; i++) run_one('h04 + (i % 2) * 'h08, 220, 1 + i % 2);

        // R8 wrap-around corner: reg 0xFFFF + 1 = 0, reg 0x0000 - 128 = 0xFF80
        breg[3] = 16'hFFFF; breg[1] = 16'h0000;
        mem[300] = 8'h45; mem[301] = 8'h03; mem[302] = 8'h01;
        launch(300); wait_done(cyc);
        chk(op1_val == 16'h0000 && length == 3'd3, "R8 offset wraps upward", int'(op1_val), 0);
        @(negedge clk);
        mem[310] = 8'h45; mem[311] = 8'h01; mem[312] = 8'h80;
        launch(310); wait_done(cyc);
        chk(op1_val == 16'hFF80, "R8 negative offset", int'(op1_val), 'hFF80);
        @(negedge clk);

        // R7 big-endian word
        mem[320] = 8'h46; mem[321] = 8'hAB; mem[322] = 8'hCD;
        launch(320); wait_done(cyc);
        chk(op1_val == 16'hABCD, "R7 big-endian order", int'(op1_val), 'hABCD);

        // R12 results held after done
        hold = op1_val;
        repeat (4) @(negedge clk);
        chk(done == 0 && mem_rd == 0 && op1_val == hold && length == 3'd3, "R12 hold after done",
            int'(op1_val), int'(hold));

        // Same-cycle: start accepted in the done cycle (R2, R6)
        for (int i = 0; i < 20; i++) begin
            build('h08, 400, 0, e1);
            build(i % 2 ? 'h02 : 'h0E, 500, 0, e2);
            launch(400); wait_done(cyc); judge(e1, cyc);
            start = 1'b1; start_addr = 16'd500;
            @(negedge clk); start = 1'b0;
            chk(mem_rd && mem_addr == 16'd500, "R2 start in done cycle", int'(mem_addr), 500);
            wait_done(cyc); judge(e2, cyc);
            @(negedge clk);
        end

        // R2 start during a fetch is ignored
        build('h08, 600, 0, e1);
        launch(600);
        @(negedge clk);
        start = 1'b1; start_addr = 16'd700;
        @(negedge clk);
        start = 1'b0;
        chk(mem_addr == 16'd602, "R2 start while busy ignored", int'(mem_addr), 602);
        cyc = 2;
        while (done !== 1'b1 && cyc < 40) begin @(negedge clk); cyc++; end
        judge(e1, cyc);
        @(negedge clk);
        chk(mem_rd == 0, "R2 no restart after busy start", int'(mem_rd), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule